// File: doc/BRIEF.md
# Aliased Partial-Access General-Purpose Register File

This block holds eight 32-bit general-purpose registers. It has one write port and two read ports. Every port names a register index and an access width. The width is one of four choices: the full word, the lower half-word, the low byte, or the high byte of the lower half. A narrow write changes only the field it names and keeps every other bit of the register. A narrow read returns its field in the low bits of a 32-bit bus, with zeros above it.

The lower four registers accept all four widths. The upper four accept only the full word and the lower half. If a port asks for a byte on an upper register, its illegal flag goes high. An illegal write changes nothing, and an illegal read returns zero.

Writes are registered on the rising clock edge. Reads are combinational from the stored state, with no forwarding from the write port. The block suits a datapath that decodes operand width elsewhere and needs the merge and extract logic kept inside the storage.

Top module: `gpr_alias_file`

## Requirements
- R1: While rst_n is low, every register is cleared to zero, and after reset every register reads as zero at every width.
- R2: Width code 2'b00 selects the full word. A write replaces all 32 bits, and a read returns all 32 bits.
- R3: Width code 2'b01 selects bits 15:0. A write takes wr_data[15:0] and keeps bits 31:16. A read returns bits 15:0 with bits 31:16 of the bus at zero.
- R4: Width code 2'b10 selects bits 7:0. A write takes wr_data[7:0] and keeps bits 31:8. A read returns bits 7:0 with bits 31:8 of the bus at zero.
- R5: Width code 2'b11 selects bits 15:8. A write takes the byte on wr_data[7:0] and keeps bits 31:16 and 7:0. A read returns bits 15:8 on bus bits 7:0, with bits 31:8 of the bus at zero.
- R6: Indices 0 to 3 accept all four widths. Indices 4 to 7 with width 2'b10 or 2'b11 raise that port's illegal flag. wr_illegal is raised only while wr_en is high. The read flags depend only on index and width.
- R7: A write flagged illegal leaves every register unchanged, and a read flagged illegal returns zero.
- R8: A write takes effect at the rising clock edge. A read of the same register in the cycle of the write returns the old value.
- R9: The two read ports work independently. They may read the same register, or different registers at different widths, in the same cycle.
- R10: While wr_en is low, no register changes, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Write register index |
| wr_size | input | 2 | Write access width code |
| wr_data | input | 32 | Write data; narrow fields come from the low bits |
| wr_illegal | output | 1 | Write request is not allowed |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_size | input | 2 | Read port 0 access width code |
| rd0_data | output | 32 | Read port 0 data, zero-extended |
| rd0_illegal | output | 1 | Read port 0 request is not allowed |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_size | input | 2 | Read port 1 access width code |
| rd1_data | output | 32 | Read port 1 data, zero-extended |
| rd1_illegal | output | 1 | Read port 1 request is not allowed |

## Verification
The hardest case to reach is a byte-high write that lands on top of a word already holding distinct values in every field. Only with such a word does a merge fault show up as a corrupted neighbour. The stimulus first fills a register with a full-word pattern whose four bytes all differ. It then writes the high byte, and reads the result back at all four widths on both ports in one cycle. The same-cycle old-value case is reached by setting a read of the target register in the very cycle the write is presented. The read is sampled before the edge and again after it.

// File: rtl/gpr_alias_pkg.sv
package gpr_alias_pkg;

  typedef enum logic [1:0] {
    ACC_WORD = 2'b00,
    ACC_HALF = 2'b01,
    ACC_LOW  = 2'b10,
    ACC_HIGH = 2'b11
  } acc_size_e;

endpackage

// File: rtl/gpr_access_check.sv
module gpr_access_check
  import gpr_alias_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int NARROW_REGS = 4,
  localparam int IDX_W      = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       size,
  output logic             legal
);

  logic byte_req;
  logic byte_ok;

  always_comb begin
    byte_req = (acc_size_e'(size) == ACC_LOW) || (acc_size_e'(size) == ACC_HIGH);
    byte_ok  = (int'(idx) < NARROW_REGS);
    legal    = !byte_req || byte_ok;
  end

endmodule

// File: rtl/gpr_write_merge.sv
module gpr_write_merge
  import gpr_alias_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] new_val,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] merged
);

  logic [DATA_W-1:0] field_mask;
  logic [DATA_W-1:0] placed;

  always_comb begin
    field_mask = '0;
    placed     = new_val;
    case (acc_size_e'(size))
      ACC_WORD: field_mask = '1;
      ACC_HALF: field_mask[HALF_W-1:0] = '1;
      ACC_LOW:  field_mask[BYTE_W-1:0] = '1;
      ACC_HIGH: begin
        field_mask[2*BYTE_W-1:BYTE_W] = '1;
        placed = new_val << BYTE_W;
      end
      default:  field_mask = '0;
    endcase
    merged = (old_val & ~field_mask) | (placed & field_mask);
  end

endmodule

// File: rtl/gpr_read_extract.sv
module gpr_read_extract
  import gpr_alias_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] reg_val,
  input  logic [1:0]        size,
  input  logic              legal,
  output logic [DATA_W-1:0] rd_val
);

  always_comb begin
    rd_val = '0;
    if (legal) begin
      case (acc_size_e'(size))
        ACC_WORD: rd_val = reg_val;
        ACC_HALF: rd_val[HALF_W-1:0] = reg_val[HALF_W-1:0];
        ACC_LOW:  rd_val[BYTE_W-1:0] = reg_val[BYTE_W-1:0];
        ACC_HIGH: rd_val[BYTE_W-1:0] = reg_val[2*BYTE_W-1:BYTE_W];
        default:  rd_val = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpr_alias_file.sv
module gpr_alias_file
  import gpr_alias_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int NARROW_REGS = 4,
  parameter int DATA_W      = 32,
  parameter int BYTE_W      = 8,
  localparam int IDX_W      = $clog2(NUM_REGS),
  localparam int NUM_RD     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_illegal,
  input  logic [IDX_W-1:0]  rd0_idx,
  input  logic [1:0]        rd0_size,
  output logic [DATA_W-1:0] rd0_data,
  output logic              rd0_illegal,
  input  logic [IDX_W-1:0]  rd1_idx,
  input  logic [1:0]        rd1_size,
  output logic [DATA_W-1:0] rd1_data,
  output logic              rd1_illegal
);

  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_d;
  logic [NUM_REGS-1:0]             wr_hit;
  logic                            wr_legal;
  logic [DATA_W-1:0]               wr_old;
  logic [DATA_W-1:0]               wr_merged;

  gpr_access_check #(
    .NUM_REGS    (NUM_REGS),
    .NARROW_REGS (NARROW_REGS)
  ) u_wr_check (
    .idx   (wr_idx),
    .size  (wr_size),
    .legal (wr_legal)
  );

  assign wr_illegal = wr_en && !wr_legal;
  assign wr_old     = regs_q[wr_idx];

  gpr_write_merge #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W)
  ) u_merge (
    .old_val (wr_old),
    .new_val (wr_data),
    .size    (wr_size),
    .merged  (wr_merged)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_comb begin
      wr_hit[k] = wr_en && wr_legal && (int'(wr_idx) == k);
      regs_d[k] = wr_hit[k] ? wr_merged : regs_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[k] <= '0;
      end else if (wr_hit[k]) begin
        regs_q[k] <= regs_d[k];
      end
    end
  end

  logic [NUM_RD-1:0][IDX_W-1:0]  rp_idx;
  logic [NUM_RD-1:0][1:0]        rp_size;
  logic [NUM_RD-1:0][DATA_W-1:0] rp_data;
  logic [NUM_RD-1:0]             rp_legal;

  assign rp_idx[0]  = rd0_idx;
  assign rp_size[0] = rd0_size;
  assign rp_idx[1]  = rd1_idx;
  assign rp_size[1] = rd1_size;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rport
    logic [DATA_W-1:0] raw;
    assign raw = regs_q[rp_idx[p]];

    gpr_access_check #(
      .NUM_REGS    (NUM_REGS),
      .NARROW_REGS (NARROW_REGS)
    ) u_rd_check (
      .idx   (rp_idx[p]),
      .size  (rp_size[p]),
      .legal (rp_legal[p])
    );

    gpr_read_extract #(
      .DATA_W (DATA_W),
      .BYTE_W (BYTE_W)
    ) u_extract (
      .reg_val (raw),
      .size    (rp_size[p]),
      .legal   (rp_legal[p]),
      .rd_val  (rp_data[p])
    );
  end

  assign rd0_data    = rp_data[0];
  assign rd1_data    = rp_data[1];
  assign rd0_illegal = !rp_legal[0];
  assign rd1_illegal = !rp_legal[1];

endmodule

// File: rtl/gpr_alias_file_chk.sv
module gpr_alias_file_chk
  import gpr_alias_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int HALF_W  = DATA_W / 2
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            wr_en,
  input logic [IDX_W-1:0]                wr_idx,
  input logic [1:0]                      wr_size,
  input logic [DATA_W-1:0]               wr_data,
  input logic                            wr_illegal,
  input logic [1:0]                      rd0_size,
  input logic [DATA_W-1:0]               rd0_data,
  input logic                            rd0_illegal,
  input logic [DATA_W-1:0]               rd1_data,
  input logic                            rd1_illegal,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);

  a_r2_word_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_illegal && wr_size == 2'b00)
      |=> regs_q[$past(wr_idx)] == $past(wr_data));

  a_r3_half_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_illegal && wr_size != 2'b00)
      |=> regs_q[$past(wr_idx)][DATA_W-1:HALF_W] == $past(regs_q[wr_idx][DATA_W-1:HALF_W]));

  a_r7_illegal_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    wr_illegal |=> regs_q == $past(regs_q));

  a_r7_illegal_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_illegal |-> rd0_data == '0) and (rd1_illegal |-> rd1_data == '0));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> regs_q == $past(regs_q));

  a_r4_narrow_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_size != 2'b00) |-> rd0_data[DATA_W-1:HALF_W] == '0);

  a_r6_wr_flag_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !wr_illegal);

endmodule

bind gpr_alias_file gpr_alias_file_chk #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_size     (wr_size),
  .wr_data     (wr_data),
  .wr_illegal  (wr_illegal),
  .rd0_size    (rd0_size),
  .rd0_data    (rd0_data),
  .rd0_illegal (rd0_illegal),
  .rd1_data    (rd1_data),
  .rd1_illegal (rd1_illegal),
  .regs_q      (regs_q)
);

// File: tb/test_gpr_alias_file.sv
`timescale 1ns/1ps
module test_gpr_alias_file;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [1:0]  wr_size;
  logic [31:0] wr_data;
  logic        wr_illegal;
  logic [2:0]  rd0_idx, rd1_idx;
  logic [1:0]  rd0_size, rd1_size;
  logic [31:0] rd0_data, rd1_data;
  logic        rd0_illegal, rd1_illegal;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [31:0] model [8];

  always #10 clk = ~clk;

  gpr_alias_file i_gpr_alias_file (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data),
    .wr_illegal(wr_illegal),
    .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data), .rd0_illegal(rd0_illegal),
    .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_data(rd1_data), .rd1_illegal(rd1_illegal)
  );

  function automatic logic [31:0] exp_read(int idx, logic [1:0] sz);
    logic [31:0] v = model[idx];
    if (idx >= 4 && sz[1]) return 32'h0;
    case (sz)
      2'b00:   return v;
      2'b01:   return {16'h0, v[15:0]};
      2'b10:   return {24'h0, v[7:0]};
      default: return {24'h0, v[15:8]};
    endcase
  endfunction

  function automatic void model_write(int idx, logic [1:0] sz, logic [31:0] d);
    if (idx >= 4 && sz[1]) return;
    case (sz)
      2'b00:   model[idx] = d;
      2'b01:   model[idx][15:0] = d[15:0];
      2'b10:   model[idx][7:0] = d[7:0];
      default: model[idx][15:8] = d[7:0];
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_check(string req, int p, int idx, logic [1:0] sz);
    if (p == 0) begin rd0_idx = idx[2:0]; rd0_size = sz; end
    else        begin rd1_idx = idx[2:0]; rd1_size = sz; end
    #1;
    check(req, (p == 0) ? rd0_data : rd1_data, exp_read(idx, sz));
  endtask

  task automatic do_write(int idx, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx[2:0]; wr_size = sz; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(idx, sz, d);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
    for (int i = 0; i < 8; i++) begin
      read_check("R1 word after reset", 0, i, 2'b00);
      read_check("R1 half after reset", 1, i, 2'b01);
    end
  endtask

  task automatic t_word;
    do_write(0, 2'b00, 32'hA1B2C3D4);
    do_write(6, 2'b00, 32'h13572468);
    read_check("R2 word read reg0", 0, 0, 2'b00);
    read_check("R2 word read reg6", 1, 6, 2'b00);
  endtask

  task automatic t_half;
    do_write(1, 2'b00, 32'h11223344);
    do_write(1, 2'b01, 32'hFFFF5566);
    read_check("R3 half keeps upper", 0, 1, 2'b00);
    read_check("R3 half read zero-ext", 1, 1, 2'b01);
    do_write(5, 2'b00, 32'hCAFEF00D);
    do_write(5, 2'b01, 32'h00009876);
    read_check("R3 half on upper reg", 0, 5, 2'b00);
  endtask

  task automatic t_bytes;
    do_write(2, 2'b00, 32'h8899AABB);
    do_write(2, 2'b10, 32'hFFFFFF5C);
    read_check("R4 low byte merge", 0, 2, 2'b00);
    read_check("R4 low byte read", 1, 2, 2'b10);
    do_write(3, 2'b00, 32'h0123ABCD);
    do_write(3, 2'b11, 32'hFFFFFFE7);
    read_check("R5 high byte merge", 0, 3, 2'b00);
    read_check("R5 high byte read", 1, 3, 2'b11);
    read_check("R5 low byte intact", 0, 3, 2'b10);
    read_check("R5 half view", 1, 3, 2'b01);
  endtask

  task automatic t_illegal;
    do_write(7, 2'b00, 32'h7777AAAA);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd7; wr_size = 2'b10; wr_data = 32'h00000055;
    #1;
    check("R6 wr_illegal byte on reg7", {31'b0, wr_illegal}, 32'd1);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd4; wr_size = 2'b11; wr_data = 32'h00000066;
    #1;
    check("R6 wr_illegal high on reg4", {31'b0, wr_illegal}, 32'd1);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R6 wr_illegal needs wr_en", {31'b0, wr_illegal}, 32'd0);
    read_check("R7 illegal write no effect reg7", 0, 7, 2'b00);
    read_check("R7 illegal write no effect reg4", 1, 4, 2'b00);
    read_check("R7 illegal read zero", 0, 7, 2'b10);
    check("R6 rd0_illegal flag", {31'b0, rd0_illegal}, 32'd1);
    read_check("R6 legal byte on reg3", 1, 3, 2'b11);
    check("R6 rd1 legal flag", {31'b0, rd1_illegal}, 32'd0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd1; wr_size = 2'b00; wr_data = 32'hDEADBEEF;
    rd0_idx = 3'd1; rd0_size = 2'b00;
    #1;
    check("R8 old value before edge", rd0_data, model[1]);
    @(negedge clk);
    wr_en = 1'b0;
    model_write(1, 2'b00, 32'hDEADBEEF);
    read_check("R8 new value after edge", 0, 1, 2'b00);
  endtask

  task automatic t_dual;
    rd0_idx = 3'd3; rd0_size = 2'b00;
    rd1_idx = 3'd3; rd1_size = 2'b11;
    #1;
    check("R9 port0 same reg", rd0_data, exp_read(3, 2'b00));
    check("R9 port1 same reg", rd1_data, exp_read(3, 2'b11));
    read_check("R9 port0 other reg", 0, 0, 2'b01);
    read_check("R9 port1 other reg", 1, 6, 2'b00);
  endtask

  task automatic t_idle;
    @(negedge clk);
    wr_en = 1'b0; wr_idx = 3'd0; wr_size = 2'b00; wr_data = 32'h5A5A5A5A;
    @(negedge clk);
    @(negedge clk);
    read_check("R10 idle no write", 0, 0, 2'b00);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_size = '0; wr_data = '0;
    rd0_idx = '0; rd0_size = '0; rd1_idx = '0; rd1_size = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word();
    t_half();
    t_bytes();
    t_illegal();
    t_same_cycle();
    t_dual();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule